// File: doc/BRIEF.md
# Length-Addressed Three-Wire Control Register Port

This block is a write-only serial receiver that loads the control registers of a frequency synthesizer from a three-wire bus. The bus has an enable line, a data line and a bit clock. A host raises enable, presents one data bit per rising bit-clock edge, and then drops enable. The block counts the bit-clock edges that arrive while enable is high. That count selects the register width, either 16 or 24 bits. Two address bits at the top of the last byte then pick one register of that width.

All three bus lines are synchronized into a faster system clock, and every edge is detected in that domain. The received word changes no register until enable falls. It is then decoded and written into one of five registers, whose fields drive parallel outputs. The outputs are:
- the reference and feedback divider values;
- the pump-current code;
- the buffer-off flag;
- the tracking-DAC code;
- four switch-off flags and the DAC mode flag;
- gain and offset codes for two alignment DACs;
- the crystal load-tuning code.

Frames with an unsupported edge count, or with an address that names no register, are dropped without effect.

Top module: `tw_reg_port`

## Requirements
- R1: While `rst` is high, and after it, until a frame is committed, the outputs hold these values: both dividers 0, pump code 0, buffer-off 0, tracking-DAC code 0, switch-off flags 4'b1111, DAC mode 0, both gains 53, both offsets 31, crystal tuning 0.
- R2: A rising edge of enable clears the edge count and the shift contents. Only rising bit-clock edges seen while the synchronized enable is high are counted. A bit-clock rise that lands in the same system cycle as enable's rise is counted. A bit-clock rise that lands in the same system cycle as enable's fall is not counted.
- R3: Bits are received least significant first. The first bit becomes bit 0 of the word, and the last bit becomes bit 15 (16-bit frame) or bit 23 (24-bit frame).
- R4: A 24-bit frame with word[23:22]=00 loads: reference divider = word[15:0], tracking-DAC code = word[18:16], buffer-off = word[19], pump code = word[21:20].
- R5: A 24-bit frame with word[23:22]=01 loads: feedback divider = word[15:0], switch-off flags = word[19:16] (bit 16 is switch 1), DAC mode = word[20] (1 selects AM).
- R6: A 16-bit frame with word[15:14]=00 loads gain1 = word[7:0] and offset1 = word[13:8]. With word[15:14]=01 it loads gain2 and offset2 from the same bit positions.
- R7: A 16-bit frame with word[15:14]=10 loads crystal tuning = word[13:6]. Bits 5:0 are ignored.
- R8: A frame whose edge count is neither 16 nor 24 changes no output.
- R9: A 24-bit frame with address 10 or 11, or a 16-bit frame with address 11, changes no output.
- R10: Outputs change only after enable falls. While enable is still high they keep their old values, even after 16 or 24 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en_i | input | 1 | Bus enable, frames a command while high |
| bus_clk_i | input | 1 | Bus bit clock, data sampled on its rise |
| bus_dat_i | input | 1 | Bus serial data |
| r_div_o | output | 16 | Reference divider value |
| n_div_o | output | 16 | Feedback divider value |
| pump_code_o | output | 2 | Charge-pump current code (00..11 = 25, 100, 500, 2000 uA) |
| buf_off_o | output | 1 | Oscillator buffer off when 1 |
| dac3_code_o | output | 3 | Tracking-DAC level code |
| sw_off_o | output | 4 | Switch-off flags, 0 pulls the switch to ground |
| dac_am_o | output | 1 | Alignment DAC mode, 1 = AM, 0 = FM |
| gain1_o | output | 8 | Alignment DAC 1 gain code |
| offs1_o | output | 6 | Alignment DAC 1 offset code |
| gain2_o | output | 8 | Alignment DAC 2 gain code |
| offs2_o | output | 6 | Alignment DAC 2 offset code |
| xtal_tune_o | output | 8 | Crystal load-capacitance code |

## Verification
Two of this block's functions can land in the same system cycle: the start or end of a frame, and the sampling of a bit-clock edge. This happens because enable and the bit clock pass through matching synchronizers. The bench provokes this by switching enable and the bit clock in the same instant. At the start of a frame, a 16-bit frame whose first edge coincides with enable's rise must still land as a 16-bit write. At the end, a 24-bit frame whose last edge coincides with enable's fall must be dropped as a 23-edge frame, and a 25-edge frame ending the same way must land as a 24-bit write. Around these cases, the bench sweeps every frame length from 0 to 26 and every address of both widths, and compares all outputs with a model of the register map after each frame.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;
  localparam int LEN_SHORT = 16;
  localparam int LEN_LONG  = 24;
  localparam int DIV_W     = 16;
  localparam int GAIN_W    = 8;
  localparam int OFFS_W    = 6;
  localparam int XTAL_W    = 8;
  localparam int SW_N      = 4;
  localparam logic [GAIN_W-1:0] GAIN_MID = GAIN_W'(53);
  localparam logic [OFFS_W-1:0] OFFS_MID = OFFS_W'(31);

  typedef enum logic [1:0] {
    ADR_0 = 2'b00,
    ADR_1 = 2'b01,
    ADR_2 = 2'b10,
    ADR_3 = 2'b11
  } reg_adr_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/tw_frame_rx.sv
module tw_frame_rx #(
  parameter int LEN_LONG = 24,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_s,
  input  logic                bclk_s,
  input  logic                dat_s,
  output logic                start_o,
  output logic                commit_o,
  output logic [CNT_W-1:0]    len_o,
  output logic [LEN_LONG-1:0] word_o
);
  logic en_q, bclk_q;
  logic start, finish, sample;

  assign start   = en_s & ~en_q;
  assign finish  = ~en_s & en_q;
  assign sample  = bclk_s & ~bclk_q & en_s;
  assign start_o = start;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      bclk_q   <= 1'b0;
      commit_o <= 1'b0;
      len_o    <= '0;
      word_o   <= '0;
    end else begin
      en_q     <= en_s;
      bclk_q   <= bclk_s;
      commit_o <= finish;
      if (start) begin
        len_o  <= sample ? CNT_W'(1) : '0;
        word_o <= sample ? {dat_s, {(LEN_LONG-1){1'b0}}} : '0;
      end else if (sample) begin
        word_o <= {dat_s, word_o[LEN_LONG-1:1]};
        if (len_o != '1) len_o <= len_o + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_reg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 commit_i,
  input  logic [CNT_W-1:0]     len_i,
  input  logic [LEN_LONG-1:0]  word_i,
  output logic [DIV_W-1:0]     r_div_o,
  output logic [DIV_W-1:0]     n_div_o,
  output logic [1:0]           pump_code_o,
  output logic                 buf_off_o,
  output logic [2:0]           dac3_code_o,
  output logic [SW_N-1:0]      sw_off_o,
  output logic                 dac_am_o,
  output logic [GAIN_W-1:0]    gain1_o,
  output logic [OFFS_W-1:0]    offs1_o,
  output logic [GAIN_W-1:0]    gain2_o,
  output logic [OFFS_W-1:0]    offs2_o,
  output logic [XTAL_W-1:0]    xtal_tune_o
);
  localparam int SHORT_LSB = LEN_LONG - LEN_SHORT;

  logic                 is_long, is_short;
  logic [LEN_SHORT-1:0] wshort;
  reg_adr_e             adr_long, adr_short;

  assign is_long   = commit_i && (len_i == CNT_W'(LEN_LONG));
  assign is_short  = commit_i && (len_i == CNT_W'(LEN_SHORT));
  assign wshort    = word_i[LEN_LONG-1:SHORT_LSB];
  assign adr_long  = reg_adr_e'(word_i[LEN_LONG-1 -: 2]);
  assign adr_short = reg_adr_e'(wshort[LEN_SHORT-1 -: 2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_div_o     <= '0;
      n_div_o     <= '0;
      pump_code_o <= '0;
      buf_off_o   <= 1'b0;
      dac3_code_o <= '0;
      sw_off_o    <= '1;
      dac_am_o    <= 1'b0;
      gain1_o     <= GAIN_MID;
      offs1_o     <= OFFS_MID;
      gain2_o     <= GAIN_MID;
      offs2_o     <= OFFS_MID;
      xtal_tune_o <= '0;
    end else begin
      if (is_long) begin
        case (adr_long)
          ADR_0: begin
            r_div_o     <= word_i[DIV_W-1:0];
            dac3_code_o <= word_i[DIV_W+2:DIV_W];
            buf_off_o   <= word_i[DIV_W+3];
            pump_code_o <= word_i[DIV_W+5:DIV_W+4];
          end
          ADR_1: begin
            n_div_o  <= word_i[DIV_W-1:0];
            sw_off_o <= word_i[DIV_W+SW_N-1:DIV_W];
            dac_am_o <= word_i[DIV_W+SW_N];
          end
          default: ;
        endcase
      end
      if (is_short) begin
        case (adr_short)
          ADR_0: begin
            gain1_o <= wshort[GAIN_W-1:0];
            offs1_o <= wshort[GAIN_W+OFFS_W-1:GAIN_W];
          end
          ADR_1: begin
            gain2_o <= wshort[GAIN_W-1:0];
            offs2_o <= wshort[GAIN_W+OFFS_W-1:GAIN_W];
          end
          ADR_2: xtal_tune_o <= wshort[LEN_SHORT-3 -: XTAL_W];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_reg_port.sv
module tw_reg_port
  import tw_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en_i,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  output logic [DIV_W-1:0]  r_div_o,
  output logic [DIV_W-1:0]  n_div_o,
  output logic [1:0]        pump_code_o,
  output logic              buf_off_o,
  output logic [2:0]        dac3_code_o,
  output logic [SW_N-1:0]   sw_off_o,
  output logic              dac_am_o,
  output logic [GAIN_W-1:0] gain1_o,
  output logic [OFFS_W-1:0] offs1_o,
  output logic [GAIN_W-1:0] gain2_o,
  output logic [OFFS_W-1:0] offs2_o,
  output logic [XTAL_W-1:0] xtal_tune_o
);
  localparam int BUS_W = 3;

  logic [BUS_W-1:0]    bus_s;
  logic                frm_start, frm_commit;
  logic [CNT_W-1:0]    frm_len;
  logic [LEN_LONG-1:0] frm_word;

  tw_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_i ({bus_en_i, bus_clk_i, bus_dat_i}),
    .sync_o  (bus_s)
  );

  tw_frame_rx #(.LEN_LONG(LEN_LONG), .CNT_W(CNT_W)) rx_i (
    .clk      (clk),
    .rst      (rst),
    .en_s     (bus_s[2]),
    .bclk_s   (bus_s[1]),
    .dat_s    (bus_s[0]),
    .start_o  (frm_start),
    .commit_o (frm_commit),
    .len_o    (frm_len),
    .word_o   (frm_word)
  );

  tw_reg_bank #(.CNT_W(CNT_W)) bank_i (
    .clk         (clk),
    .rst         (rst),
    .commit_i    (frm_commit),
    .len_i       (frm_len),
    .word_i      (frm_word),
    .r_div_o     (r_div_o),
    .n_div_o     (n_div_o),
    .pump_code_o (pump_code_o),
    .buf_off_o   (buf_off_o),
    .dac3_code_o (dac3_code_o),
    .sw_off_o    (sw_off_o),
    .dac_am_o    (dac_am_o),
    .gain1_o     (gain1_o),
    .offs1_o     (offs1_o),
    .gain2_o     (gain2_o),
    .offs2_o     (offs2_o),
    .xtal_tune_o (xtal_tune_o)
  );
endmodule

// File: rtl/tw_reg_port_chk.sv
module tw_reg_port_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             commit,
  input logic [CNT_W-1:0] len,
  input logic [34:0]      long_regs,
  input logic [35:0]      short_regs
);
  AST_RESET_VALUES: assert property (@(posedge clk)
    rst |=> (short_regs == {8'd53, 6'd31, 8'd53, 6'd31, 8'd0} && long_regs == {16'd0, 16'd0, 2'd0, 1'b0} ))
    else $error("reset values"); // R1

  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    start |=> (len <= CNT_W'(1)))
    else $error("count not cleared at frame start"); // R2

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(long_regs) && $stable(short_regs)))
    else $error("output changed without commit"); // R10

  AST_LONG_ONLY_ON_24: assert property (@(posedge clk) disable iff (rst)
    (commit && len != CNT_W'(24)) |=> $stable(long_regs))
    else $error("24-bit register written by other length"); // R8

  AST_SHORT_ONLY_ON_16: assert property (@(posedge clk) disable iff (rst)
    (commit && len != CNT_W'(16)) |=> $stable(short_regs))
    else $error("16-bit register written by other length"); // R8
endmodule

bind tw_reg_port tw_reg_port_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start      (frm_start),
  .commit     (frm_commit),
  .len        (frm_len),
  .long_regs  ({r_div_o, n_div_o, pump_code_o, dac_am_o}),
  .short_regs ({gain1_o, offs1_o, gain2_o, offs2_o, xtal_tune_o})
);

// File: tb/tw_reg_port_tb_top.sv
module tw_reg_port_tb_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0, bus_clk = 1'b0, bus_dat = 1'b0;

  logic [15:0] r_div, n_div;
  logic [1:0]  pump;
  logic        boff, am;
  logic [2:0]  dac3;
  logic [3:0]  sw;
  logic [7:0]  g1, g2, xt;
  logic [5:0]  o1, o2;

  logic [15:0] e_r, e_n;
  logic [1:0]  e_pump;
  logic        e_boff, e_am;
  logic [2:0]  e_dac3;
  logic [3:0]  e_sw;
  logic [7:0]  e_g1, e_g2, e_xt;
  logic [5:0]  e_o1, e_o2;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tw_reg_port dut_i (
    .clk(clk), .rst(rst), .bus_en_i(bus_en), .bus_clk_i(bus_clk), .bus_dat_i(bus_dat),
    .r_div_o(r_div), .n_div_o(n_div), .pump_code_o(pump), .buf_off_o(boff),
    .dac3_code_o(dac3), .sw_off_o(sw), .dac_am_o(am), .gain1_o(g1), .offs1_o(o1),
    .gain2_o(g2), .offs2_o(o2), .xtal_tune_o(xt)
  );

  task automatic reset_model();
    e_r = '0; e_n = '0; e_pump = '0; e_boff = 1'b0; e_dac3 = '0;
    e_sw = 4'hF; e_am = 1'b0; e_g1 = 8'd53; e_o1 = 6'd31;
    e_g2 = 8'd53; e_o2 = 6'd31; e_xt = '0;
  endtask

  task automatic model(input int len, input logic [23:0] w);
    if (len == 24) begin
      case (w[23:22])
        2'b00: begin e_r = w[15:0]; e_dac3 = w[18:16]; e_boff = w[19]; e_pump = w[21:20]; end
        2'b01: begin e_n = w[15:0]; e_sw = w[19:16]; e_am = w[20]; end
        default: ;
      endcase
    end else if (len == 16) begin
      case (w[15:14])
        2'b00: begin e_g1 = w[7:0]; e_o1 = w[13:8]; end
        2'b01: begin e_g2 = w[7:0]; e_o2 = w[13:8]; end
        2'b10: e_xt = w[13:6];
        default: ;
      endcase
    end
  endtask

  task automatic check_all(input string tag);
    logic [101:0] act, exp;
    act = {r_div, n_div, pump, boff, dac3, sw, am, g1, o1, g2, o2, xt};
    exp = {e_r, e_n, e_pump, e_boff, e_dac3, e_sw, e_am, e_g1, e_o1, e_g2, e_o2, e_xt};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends n bit-clock edges carrying w[0..n-1]. co_first: first edge together
  // with enable rise. co_last: last edge together with enable fall.
  task automatic send(input int n, input logic [23:0] w, input bit co_first,
                      input bit co_last, input bit peek);
    bus_en = 1'b0; bus_clk = 1'b0;
    if (n == 0) begin
      bus_en = 1'b1; wait_cyc(H); bus_en = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      bus_dat = (i < 24) ? w[i] : 1'b0;
      if (i == 0 && !co_first) begin bus_en = 1'b1; end
      wait_cyc(H);
      if (i == 0 && co_first) begin bus_en = 1'b1; bus_clk = 1'b1; end
      else if (i == n-1 && co_last) begin bus_en = 1'b0; bus_clk = 1'b1; end
      else bus_clk = 1'b1;
      wait_cyc(H);
      bus_clk = 1'b0;
    end
    if (n > 0 && !co_last) begin
      wait_cyc(H);
      if (peek) check_all("R10 hold while enable high");
      bus_en = 1'b0;
    end
    wait_cyc(3*H);
  endtask

  initial begin
    logic [23:0] w;
    reset_model();
    wait_cyc(5);
    check_all("R1 during reset");
    rst = 1'b0;
    wait_cyc(4);
    check_all("R1 after reset");

    // R3 R4 R5 R6 R7 R9: every address of both lengths, two payloads each
    for (int k = 0; k < 2; k++) begin
      for (int L = 16; L <= 24; L += 8) begin
        for (int a = 0; a < 4; a++) begin
          w = 24'((a * 24'h3A5C7 + L * 24'h1F3B + k * 24'h5B1E9) ^ 24'h96E1D4);
          if (L == 24) w[23:22] = 2'(a); else w[15:14] = 2'(a);
          send(L, w, 1'b0, 1'b0, (a == 0));
          model(L, w);
          check_all("R3 R4 R5 R6 R7 R9 address sweep");
        end
      end
    end

    // R8: every length 0..26
    for (int L = 0; L <= 26; L++) begin
      w = 24'h4A3C75 ^ 24'(L * 24'h010203);
      w[15:14] = 2'b00;
      w[23:22] = 2'b01;
      send(L, w, 1'b0, 1'b0, 1'b0);
      model(L, w);
      check_all("R8 length sweep");
    end

    // R2: first edge coincides with enable rise -> still 16 edges
    w = 24'h00_5A_C3; w[15:14] = 2'b01;
    send(16, w, 1'b1, 1'b0, 1'b0);
    model(16, w);
    check_all("R2 first edge with enable rise");

    // R2: last edge coincides with enable fall -> 23 edges, dropped
    w = 24'h1E_77_21;
    send(24, w, 1'b0, 1'b1, 1'b0);
    check_all("R2 last edge with enable fall dropped");

    // R2: 25 edges, last with enable fall -> 24 counted
    w = 24'h0B_BE_EF;
    send(25, w, 1'b0, 1'b1, 1'b0);
    model(24, w);
    check_all("R2 25th edge with enable fall ignored");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule